// File: doc/BRIEF.md
# Host Bus Access Sequencer

This block drives an asynchronous, non-multiplexed peripheral bus from the host side. The bus has a 3-bit register address, an active-low chip select, separate active-low read and write strobes, and a 16-bit data path. Commands arrive on a ready/valid port. Each command carries the direction, the target register and the write data. The sequencer runs each access through an address/select setup phase, a strobe-low phase and a hold phase. Every phase is sized in system-clock cycles, rounded up from nanosecond minimums that are given as parameters.

Between accesses the block enforces a minimum spacing, measured from the rise of one strobe to the fall of the next. The spacing depends on the pair of accesses. After a write to the pointer-low register, any following strobe waits at least four arbitration periods. A pointer-low write that directly follows a write or read of the data register waits at least five arbitration periods. Otherwise only the plain strobe-high minimum applies. The arbitration period is a configurable number of system clocks, and it doubles while the slow-arbitration input is high. Read data is sampled on the last edge of the read strobe and returned on a response port with a one-cycle valid pulse.

Top module: `hbus_access_seq`

## Requirements
- R1: After reset the chip select, read strobe and write strobe are high, `rsp_valid` is low, and `cmd_ready` is high.
- R2: Chip select falls and the address is driven SU cycles before the strobe falls, where SU = max(ceil(15 ns/Tclk), ceil(5 ns/Tclk)) (2 at defaults). Only the strobe matching the command direction goes low, and only one strobe is ever low at a time.
- R3: A strobe stays low for LOW = max(ceil(20 ns/Tclk), ceil(30 ns/Tclk) - SU) cycles (3 at defaults).
- R4: After the strobe rises, address and chip select are held for HD = ceil(10 ns/Tclk) cycles (2 at defaults), and then chip select goes high.
- R5: For a write, `bus_data_oe` is high and `bus_data_out` carries the command data while the write strobe is low. For a read, `bus_data_oe` is low.
- R6: A read samples `bus_data_in` on the clock edge that releases the read strobe. That value appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, starting in the cycle the strobe is high again.
- R7: With a command already waiting, the number of cycles from a strobe rise to the next strobe fall equals the larger of the required minimum and SU+HD+1. The minimum is never below ceil(20 ns/Tclk).
- R8: After a write to the pointer-low register (address 2), the next strobe falls no earlier than 4 arbitration periods after the rise.
- R9: A write to the pointer-low register that follows a write or a read of the data register (address 4) falls no earlier than 5 arbitration periods after the previous rise.
- R10: The arbitration period is OPR_CLK_CYC system clocks (2 at defaults) while `slow_arb` is low, and twice that while it is high.
- R11: No extended spacing applies to a pointer-low write after an access to any register other than the data register, or to a read of the pointer-low register after a data-register write. Such pairs use only the base spacing of R7.
- R12: `cmd_ready` is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_arb | input | 1 | Doubles the arbitration period when high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | Target register |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Captured read data |
| bus_addr | output | 3 | Peripheral register address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_data_out | output | 16 | Data driven toward the peripheral |
| bus_data_oe | output | 1 | Output enable for bus_data_out |
| bus_data_in | input | 16 | Data returned by the peripheral |

## Verification
Commands are issued back to back so that every spacing is exact rather than a lower bound. Several access pairs are covered. A plain data write followed by a control write shows the base spacing. A pointer write followed by any access exposes the four-period rule. Data write or data read followed by a pointer write exposes the five-period rule. A pointer write after a non-data register, and a pointer read after a data write, confirm that the longer rules are not over-applied. The same pairs are repeated with slow arbitration high, which separates the doubled period from the nominal one. Read data depends on the address, which ties each response to its own access.

// File: rtl/hbus_seq_pkg.sv
package hbus_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } phase_e;

   typedef enum logic [1:0] {
      ACC_OTHER,
      ACC_DATA_WR,
      ACC_DATA_RD,
      ACC_PTR_WR
   } acc_kind_e;

   function automatic int ceil_cyc(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hbus_gap_rule.sv
module hbus_gap_rule
   import hbus_seq_pkg::*;
#(
   parameter int BASE_CYC    = 3,
   parameter int OPR_CLK_CYC = 2,
   parameter int CW          = 6
) (
   input  acc_kind_e        last_kind,
   input  logic             next_ptr_wr,
   input  logic             slow_arb,
   output logic [CW-1:0]    req_cyc
);
   localparam int MAX_REQ = imax(BASE_CYC, 10 * OPR_CLK_CYC);

   generate
      if (OPR_CLK_CYC < 1) begin : g_bad_opr
         $error("hbus_gap_rule: OPR_CLK_CYC must be at least 1");
      end
      if (MAX_REQ >= (1 << CW)) begin : g_bad_cw
         $error("hbus_gap_rule: CW too narrow for the longest spacing");
      end
   endgenerate

   always_comb begin
      int unsigned tarb;
      int unsigned r;
      tarb = slow_arb ? 2 * OPR_CLK_CYC : OPR_CLK_CYC;
      r    = BASE_CYC;
      if (last_kind == ACC_PTR_WR && 4 * tarb > r)
         r = 4 * tarb;
      if (next_ptr_wr && (last_kind == ACC_DATA_WR || last_kind == ACC_DATA_RD)
          && 5 * tarb > r)
         r = 5 * tarb;
      req_cyc = CW'(r);
   end

endmodule

// File: rtl/hbus_since_rise.sv
module hbus_since_rise #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_evt,
   output logic [CW-1:0] since
);
   localparam logic [CW-1:0] SAT = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since <= SAT;
      else if (rise_evt)
         since <= '0;
      else if (since != SAT)
         since <= since + 1'b1;
   end

endmodule

// File: rtl/hbus_phase_ctl.sv
module hbus_phase_ctl
   import hbus_seq_pkg::*;
#(
   parameter int AW     = 3,
   parameter int DW     = 16,
   parameter int SU_CYC = 2,
   parameter int LO_CYC = 3,
   parameter int HD_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_wr,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_data,
   output logic          idle,
   output logic          rise_evt,
   output logic [AW-1:0] bus_addr,
   output logic          bus_cs_n,
   output logic          bus_rd_n,
   output logic          bus_wr_n,
   output logic [DW-1:0] bus_data_out,
   output logic          bus_data_oe,
   input  logic [DW-1:0] bus_data_in,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);
   localparam int PMAX = imax(imax(SU_CYC, LO_CYC), HD_CYC);
   localparam int PW   = $clog2(PMAX + 1);

   generate
      if (SU_CYC < 1 || LO_CYC < 1 || HD_CYC < 1) begin : g_bad_phase
         $error("hbus_phase_ctl: every phase needs at least one cycle");
      end
   endgenerate

   phase_e          phase;
   logic [PW-1:0]   pcnt;
   logic            wr_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         pcnt      <= '0;
         wr_q      <= 1'b0;
         addr_q    <= '0;
         data_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_SETUP;
               pcnt   <= PW'(SU_CYC - 1);
               wr_q   <= start_wr;
               addr_q <= start_addr;
               data_q <= start_data;
            end
            PH_SETUP: if (pcnt == '0) begin
               phase <= PH_STROBE;
               pcnt  <= PW'(LO_CYC - 1);
            end else begin
               pcnt <= pcnt - 1'b1;
            end
            PH_STROBE: if (pcnt == '0) begin
               phase <= PH_HOLD;
               pcnt  <= PW'(HD_CYC - 1);
               if (!wr_q) begin
                  rsp_rdata <= bus_data_in;
                  rsp_valid <= 1'b1;
               end
            end else begin
               pcnt <= pcnt - 1'b1;
            end
            PH_HOLD: if (pcnt == '0) begin
               phase <= PH_IDLE;
            end else begin
               pcnt <= pcnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign idle         = (phase == PH_IDLE);
   assign rise_evt     = (phase == PH_STROBE) && (pcnt == '0);
   assign bus_addr     = addr_q;
   assign bus_cs_n     = (phase == PH_IDLE);
   assign bus_wr_n     = !((phase == PH_STROBE) && wr_q);
   assign bus_rd_n     = !((phase == PH_STROBE) && !wr_q);
   assign bus_data_out = data_q;
   assign bus_data_oe  = wr_q && (phase != PH_IDLE);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_wr_n && !bus_rd_n)); // R2

   AST_CS_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n); // R2

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr)); // R4

   AST_RSP_ON_READ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(bus_rd_n)); // R6

endmodule

// File: rtl/hbus_access_seq.sv
module hbus_access_seq
   import hbus_seq_pkg::*;
#(
   parameter int ADDR_W        = 3,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_NS = 8,
   parameter int OPR_CLK_CYC   = 2,
   parameter int PTR_LO_ADDR   = 2,
   parameter int DATA_REG_ADDR = 4,
   parameter int ADDR_SU_NS    = 15,
   parameter int CS_SU_NS      = 5,
   parameter int DATA_SU_NS    = 30,
   parameter int ADDR_HD_NS    = 10,
   parameter int STB_LOW_NS    = 20,
   parameter int STB_HIGH_NS   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_arb,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic [DATA_W-1:0] bus_data_out,
   output logic              bus_data_oe,
   input  logic [DATA_W-1:0] bus_data_in
);
   localparam int SU_CYC   = imax(1, imax(ceil_cyc(ADDR_SU_NS, CLK_PERIOD_NS),
                                          ceil_cyc(CS_SU_NS, CLK_PERIOD_NS)));
   localparam int LO_CYC   = imax(1, imax(ceil_cyc(STB_LOW_NS, CLK_PERIOD_NS),
                                          ceil_cyc(DATA_SU_NS, CLK_PERIOD_NS) - SU_CYC));
   localparam int HD_CYC   = imax(1, ceil_cyc(ADDR_HD_NS, CLK_PERIOD_NS));
   localparam int BASE_CYC = ceil_cyc(STB_HIGH_NS, CLK_PERIOD_NS);
   localparam int MAX_REQ  = imax(BASE_CYC, 10 * OPR_CLK_CYC);
   localparam int CW       = $clog2(MAX_REQ + SU_CYC + HD_CYC + LO_CYC + 2) + 1;

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_clk
         $error("hbus_access_seq: CLK_PERIOD_NS must be positive");
      end
      if (PTR_LO_ADDR == DATA_REG_ADDR) begin : g_bad_map
         $error("hbus_access_seq: pointer and data registers must differ");
      end
      if (PTR_LO_ADDR >= (1 << ADDR_W) || DATA_REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("hbus_access_seq: register index outside address range");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(PTR_LO_ADDR);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_REG_ADDR);

   acc_kind_e     last_kind;
   acc_kind_e     cmd_kind;
   logic [CW-1:0] req_cyc;
   logic [CW-1:0] req_lat;
   logic [CW-1:0] since;
   logic          idle;
   logic          rise_evt;
   logic          accept;

   always_comb begin
      if (cmd_write && cmd_addr == PTR_A)
         cmd_kind = ACC_PTR_WR;
      else if (cmd_addr == DATA_A)
         cmd_kind = cmd_write ? ACC_DATA_WR : ACC_DATA_RD;
      else
         cmd_kind = ACC_OTHER;
   end

   hbus_gap_rule #(
      .BASE_CYC    (BASE_CYC),
      .OPR_CLK_CYC (OPR_CLK_CYC),
      .CW          (CW)
   ) u_gap (
      .last_kind   (last_kind),
      .next_ptr_wr (cmd_kind == ACC_PTR_WR),
      .slow_arb    (slow_arb),
      .req_cyc     (req_cyc)
   );

   hbus_since_rise #(.CW(CW)) u_since (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_evt (rise_evt),
      .since    (since)
   );

   assign cmd_ready = idle &&
      ((CW+1)'(since) + (CW+1)'(SU_CYC + 1) >= (CW+1)'(req_cyc));
   assign accept    = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_kind <= ACC_OTHER;
         req_lat   <= '0;
      end else if (accept) begin
         last_kind <= cmd_kind;
         req_lat   <= req_cyc;
      end
   end

   hbus_phase_ctl #(
      .AW     (ADDR_W),
      .DW     (DATA_W),
      .SU_CYC (SU_CYC),
      .LO_CYC (LO_CYC),
      .HD_CYC (HD_CYC)
   ) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (accept),
      .start_wr     (cmd_write),
      .start_addr   (cmd_addr),
      .start_data   (cmd_wdata),
      .idle         (idle),
      .rise_evt     (rise_evt),
      .bus_addr     (bus_addr),
      .bus_cs_n     (bus_cs_n),
      .bus_rd_n     (bus_rd_n),
      .bus_wr_n     (bus_wr_n),
      .bus_data_out (bus_data_out),
      .bus_data_oe  (bus_data_oe),
      .bus_data_in  (bus_data_in),
      .rsp_valid    (rsp_valid),
      .rsp_rdata    (rsp_rdata)
   );

   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> bus_cs_n); // R12

   AST_FALL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_wr_n) || $fell(bus_rd_n)) |-> since >= req_lat); // R7

endmodule

// File: tb/tb_hbus_access_seq.sv
module tb_hbus_access_seq;

   localparam int P    = 8;
   localparam int OPR  = 2;
   localparam int SU   = 2;   // R2: max(ceil(15/8), ceil(5/8))
   localparam int LOW  = 3;   // R3: max(ceil(20/8), ceil(30/8)-2)
   localparam int HD   = 2;   // R4: ceil(10/8)
   localparam int BASE = 3;   // R7: ceil(20/8)
   localparam logic [2:0] A_PTR  = 3'd2;
   localparam logic [2:0] A_DATA = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_arb = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_write = 1'b0;
   logic [2:0]  cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [2:0]  bus_addr;
   logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_data_oe;
   logic [15:0] bus_data_out;
   logic [15:0] bus_data_in;

   always #4 clk = ~clk;

   function automatic logic [15:0] rd_val(input logic [2:0] a);
      return {1'b1, a, a, a, a, a};
   endfunction

   assign bus_data_in = bus_rd_n ? 16'h0000 : rd_val(bus_addr);

   hbus_access_seq dut (
      .clk(clk), .rst_n(rst_n), .slow_arb(slow_arb),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_data_out(bus_data_out),
      .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in)
   );

   typedef struct {
      bit          wr;
      logic [2:0]  addr;
      logic [15:0] data;
      int          k;
      string       tag;
   } exp_t;

   exp_t        acc_q[$];
   logic [15:0] rsp_q[$];
   int checks = 0;
   int fails  = 0;
   int r12_bad = 0;
   bit done = 0;
   bit mon_on = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver-side model of the previous access
   bit         have_prev = 0;
   bit         prev_wr;
   logic [2:0] prev_addr;

   task automatic send(input bit w, input logic [2:0] a, input logic [15:0] d, input bit spaced);
      exp_t e;
      int   tarb, req, k;
      string tag;
      tarb = slow_arb ? 2 * OPR : OPR;                  // R10
      req  = BASE;
      tag  = "R7";
      if (have_prev && (prev_addr == A_DATA || (w && a == A_PTR)))
         tag = "R11";
      if (have_prev && prev_wr && prev_addr == A_PTR && 4 * tarb > req) begin
         req = 4 * tarb; tag = slow_arb ? "R10" : "R8";
      end
      if (have_prev && w && a == A_PTR && prev_addr == A_DATA && 5 * tarb > req) begin
         req = 5 * tarb; tag = slow_arb ? "R10" : "R9";
      end
      k = (req > SU + HD + 1) ? req : SU + HD + 1;
      e.wr = w; e.addr = a; e.data = d; e.k = spaced ? k : 0; e.tag = tag;
      acc_q.push_back(e);
      if (!w) rsp_q.push_back(rd_val(a));
      have_prev = 1; prev_wr = w; prev_addr = a;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
      #1;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic go_idle();
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   // monitor and scoreboard
   bit prev_low = 0;
   int cs_run = 0, low_run = 0, hold_run = 0, since = 0;
   bit in_hold = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         bit stb_low;
         exp_t e;
         stb_low = !bus_wr_n || !bus_rd_n;
         since++;
         if (!bus_cs_n && cmd_ready) r12_bad++;
         if (stb_low && !prev_low) begin
            if (acc_q.size() == 0) begin
               chk(0, "R2 unexpected strobe", 0, 1);
            end else begin
               e = acc_q.pop_front();
               chk(bus_addr == e.addr, "R2 address", int'(bus_addr), int'(e.addr));
               chk(bus_wr_n == !e.wr && bus_rd_n == e.wr, "R2 strobe type",
                   int'({bus_wr_n, bus_rd_n}), int'({!e.wr, e.wr}));
               chk(cs_run == SU, "R2 setup cycles", cs_run, SU);
               if (e.wr)
                  chk(bus_data_oe && bus_data_out == e.data, "R5 write data",
                      int'(bus_data_out), int'(e.data));
               else
                  chk(!bus_data_oe, "R5 read oe", int'(bus_data_oe), 0);
               if (e.k > 0)
                  chk(since == e.k, {e.tag, " spacing"}, since, e.k);
            end
            cs_run = 0;
            low_run = 1;
         end else if (stb_low) begin
            low_run++;
         end else if (!stb_low && prev_low) begin
            chk(low_run == LOW, "R3 strobe low width", low_run, LOW);
            since = 0;
            in_hold = 1;
            hold_run = 1;
         end else if (!bus_cs_n) begin
            if (in_hold) hold_run++;
            else cs_run++;
         end else begin
            if (in_hold) chk(hold_run == HD, "R4 hold cycles", hold_run, HD);
            in_hold = 0;
            cs_run = 0;
         end
         prev_low = stb_low;
         if (rsp_valid) begin
            if (rsp_q.size() == 0)
               chk(0, "R6 unexpected response", int'(rsp_rdata), 0);
            else begin
               logic [15:0] x;
               x = rsp_q.pop_front();
               chk(rsp_rdata == x, "R6 read data", int'(rsp_rdata), int'(x));
               chk(bus_rd_n, "R6 response after strobe release", int'(bus_rd_n), 1);
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes idle in reset",
          int'({bus_cs_n, bus_rd_n, bus_wr_n}), 7);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes idle after reset",
          int'({bus_cs_n, bus_rd_n, bus_wr_n}), 7);
      chk(!rsp_valid, "R1 no response", int'(rsp_valid), 0);
      chk(cmd_ready, "R1 ready", int'(cmd_ready), 1);
      mon_on = 1;

      // nominal arbitration, back to back
      send(1, A_DATA, 16'h1111, 0);
      send(1, 3'd1,   16'h2222, 1);  // base
      send(0, A_DATA, 16'h0000, 1);  // base
      send(1, A_PTR,  16'h0033, 1);  // data read -> ptr write: 5T
      send(0, 3'd3,   16'h0000, 1);  // after ptr write: 4T
      send(1, A_PTR,  16'h0044, 1);  // other -> ptr write: base
      send(1, A_PTR,  16'h0055, 1);  // ptr -> ptr: 4T
      send(1, A_DATA, 16'hA5A5, 1);  // after ptr write: 4T
      send(0, A_PTR,  16'h0000, 1);  // data write -> ptr read: base
      send(1, A_DATA, 16'h5A5A, 1);
      send(1, A_PTR,  16'h0066, 1);  // data write -> ptr write: 5T
      go_idle();

      // slow arbitration
      slow_arb = 1'b1;
      have_prev = 0;
      send(1, A_DATA, 16'hBEEF, 0);
      send(1, A_PTR,  16'h0077, 1);  // 5T doubled
      send(0, A_DATA, 16'h0000, 1);  // 4T doubled
      send(1, A_PTR,  16'h0088, 1);  // 5T doubled
      send(1, 3'd6,   16'h0099, 1);  // 4T doubled
      go_idle();
      slow_arb = 1'b0;

      // isolated read after idle
      send(0, 3'd7, 16'h0000, 0);
      go_idle();

      chk(acc_q.size() == 0, "R2 all accesses seen", acc_q.size(), 0);
      chk(rsp_q.size() == 0, "R6 all responses seen", rsp_q.size(), 0);
      chk(r12_bad == 0, "R12 ready low while selected", r12_bad, 0);
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

endmodule